// File: doc/BRIEF.md
# Synchronized Battery Voltage Sample Averager

This block produces the battery-voltage samples that a downstream slope detector compares against each other. Each sample is a burst of ADC conversions, spaced a fixed number of timebase ticks apart, that are summed and then divided by a power of two. The spacing lets the average cancel ripple coupled in from 50 Hz or 60 Hz mains. The burst length follows the termination mode. Modes that look for a voltage peak average 32 conversions. The mode that looks for a voltage drop averages 16.

Bursts start in one of two ways. With no external timing, an internal period fires a burst. A system can also synchronize sampling to its own activity with short high pulses on the inhibit line, and a qualifying pulse starts a burst on its falling edge. When qualifying pulses stop arriving for longer than a mode-dependent window, the block returns to its internal period. Each pulse is classified by its width in clock cycles. A short pulse is a sync event. A very long one tells the detector to discard its sample history. Anything in between is ignored.

Top module: `volt_sample_avg`

## Requirements
- R1: A burst issues 32 conversion requests when `mode_i` is 2'b00 or 2'b01 (peak modes), and 16 when `mode_i` is 2'b10 or 2'b11 (drop modes). The mode is taken when the burst starts.
- R2: `sample_o` is the truncated sum of the burst's conversion results, right-shifted by 5 for a 32-conversion burst and by 4 for a 16-conversion burst.
- R3: After each `conv_done_i`, the next request of the same burst is raised only after SPACE_TICKS further `tick_i` pulses. It is never raised on the cycle straight after the done.
- R4: With no sync events, a burst starts every FREE_TICKS ticks.
- R5: An inhibit-high pulse lasting PW_MIN_CYC to PW_SYNC_CYC clock cycles (inclusive) is a sync event. It raises `conv_req_o` two cycles after the cycle in which the falling edge is sampled.
- R6: A pulse shorter than PW_MIN_CYC, or longer than PW_SYNC_CYC but shorter than PW_CLR_CYC, starts no burst and raises no history clear.
- R7: Inhibit held high for PW_CLR_CYC cycles or more gives exactly one single-cycle `hist_clr_o` pulse, and its falling edge starts no burst.
- R8: After a sync event, free-running bursts are suppressed. Once SYNC_PK_TICKS (peak modes) or SYNC_ND_TICKS (drop modes) ticks pass with no further sync event, free running resumes, and its first burst comes FREE_TICKS ticks later.
- R9: `sample_valid_o` lasts one cycle, and `conv_req_o` stays high until `conv_done_i`. A trigger that arrives while a burst is running is dropped.
- R10: After reset, `conv_req_o`, `sample_valid_o` and `hist_clr_o` are low and `sample_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle timebase tick for spacing and periods |
| mode_i | input | 2 | Termination mode select (bit 1 set = drop mode) |
| inh_i | input | 1 | Inhibit line carrying sync and clear pulses |
| conv_req_o | output | 1 | Conversion request, held until done |
| conv_done_i | input | 1 | One-cycle conversion complete |
| conv_data_i | input | DATA_W | Conversion result, valid with done |
| sample_o | output | DATA_W | Averaged sample |
| sample_valid_o | output | 1 | One-cycle strobe for `sample_o` |
| hist_clr_o | output | 1 | One-cycle pulse asking the detector to drop its history |

## Verification
A wrong accumulator or counter state shows up at the first `sample_valid_o` that follows it, as a wrong average or a wrong number of conversion handshakes in that burst. An error in the pulse-width counter or the sync flag shows up at the ports within a few cycles for sync and clear pulses. For the fallback path it only shows up a whole window later, as a burst that starts too early, too late or not at all. For this reason the bench measures the gap from the sync edge to the next burst in each of the two window lengths. It also measures the exact free-running period and every gap between the conversions of a burst.

// File: rtl/vsa_pkg.sv
package vsa_pkg;
  localparam int PK_LOG2 = 5;
  localparam int ND_LOG2 = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_GAP} burst_st_t;

  function automatic logic is_drop_mode(input logic [1:0] m);
    return (m == 2'b10) || (m == 2'b11);
  endfunction
endpackage

// File: rtl/vsa_pulse_class.sv
module vsa_pulse_class #(
  parameter int MIN_CYC  = 2,
  parameter int SYNC_CYC = 20,
  parameter int CLR_CYC  = 60
) (
  input  logic clk,
  input  logic rst,
  input  logic inh_i,
  output logic sync_o,
  output logic clr_o
);
  localparam int CW = $clog2(CLR_CYC + 1);

  logic          inh_q;
  logic [CW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      inh_q  <= 1'b0;
      hi_cnt <= '0;
      sync_o <= 1'b0;
      clr_o  <= 1'b0;
    end else begin
      inh_q <= inh_i;
      if (inh_i) begin
        if (hi_cnt != CW'(CLR_CYC)) hi_cnt <= hi_cnt + 1'b1;
      end else begin
        hi_cnt <= '0;
      end
      clr_o  <= inh_i && (hi_cnt == CW'(CLR_CYC - 1));
      sync_o <= !inh_i && inh_q && (hi_cnt >= CW'(MIN_CYC)) && (hi_cnt <= CW'(SYNC_CYC));
    end
  end

  AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    clr_o |=> !clr_o); // R7
  AST_SYNC_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    sync_o |-> !$past(inh_i)); // R5
endmodule

// File: rtl/vsa_sched.sv
module vsa_sched #(
  parameter int FREE_T  = 400,
  parameter int SMAX_PK = 600,
  parameter int SMAX_ND = 300
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic       drop_i,
  input  logic       sync_i,
  output logic       trig_o
);
  localparam int TMAX = (FREE_T > SMAX_PK) ? ((FREE_T > SMAX_ND) ? FREE_T : SMAX_ND)
                                           : ((SMAX_PK > SMAX_ND) ? SMAX_PK : SMAX_ND);
  localparam int TW = $clog2(TMAX + 1);

  logic          synced;
  logic [TW-1:0] gap_cnt;
  logic [TW-1:0] free_cnt;
  logic [TW-1:0] gap_last;
  logic          free_fire;

  assign gap_last  = drop_i ? TW'(SMAX_ND - 1) : TW'(SMAX_PK - 1);
  assign free_fire = !synced && tick_i && (free_cnt == TW'(FREE_T - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      synced   <= 1'b0;
      gap_cnt  <= '0;
      free_cnt <= '0;
      trig_o   <= 1'b0;
    end else begin
      trig_o <= sync_i || free_fire;
      if (sync_i) begin
        synced   <= 1'b1;
        gap_cnt  <= '0;
        free_cnt <= '0;
      end else if (synced) begin
        free_cnt <= '0;
        if (tick_i) begin
          if (gap_cnt == gap_last) begin
            synced  <= 1'b0;
            gap_cnt <= '0;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
      end else if (tick_i) begin
        free_cnt <= free_fire ? '0 : free_cnt + 1'b1;
      end
    end
  end

  AST_SYNCED_NO_FREE: assert property (@(posedge clk) disable iff (rst)
    synced && !sync_i |=> !trig_o); // R8
  AST_TRIG_SOURCE: assert property (@(posedge clk) disable iff (rst)
    trig_o |-> $past(sync_i) || $past(tick_i)); // R4
endmodule

// File: rtl/vsa_burst.sv
module vsa_burst
  import vsa_pkg::*;
#(
  parameter int DW      = 10,
  parameter int SPACE_T = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          drop_i,
  input  logic          trig_i,
  output logic          req_o,
  input  logic          done_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] sample_o,
  output logic          valid_o
);
  localparam int AW = DW + PK_LOG2;
  localparam int SW = $clog2(SPACE_T + 1);

  burst_st_t           st;
  logic                drop_q;
  logic [PK_LOG2-1:0]  conv_cnt;
  logic [PK_LOG2-1:0]  conv_last;
  logic [SW-1:0]       sp_cnt;
  logic [AW-1:0]       acc;
  logic [AW-1:0]       acc_n;

  assign conv_last = drop_q ? PK_LOG2'((1 << ND_LOG2) - 1) : PK_LOG2'((1 << PK_LOG2) - 1);
  assign acc_n     = acc + {{PK_LOG2{1'b0}}, data_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      drop_q   <= 1'b0;
      conv_cnt <= '0;
      sp_cnt   <= '0;
      acc      <= '0;
      req_o    <= 1'b0;
      sample_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      case (st)
        ST_IDLE: if (trig_i) begin
          st       <= ST_REQ;
          req_o    <= 1'b1;
          acc      <= '0;
          conv_cnt <= '0;
          drop_q   <= drop_i;
        end
        ST_REQ: if (done_i) begin
          req_o <= 1'b0;
          if (conv_cnt == conv_last) begin
            sample_o <= drop_q ? acc_n[DW+ND_LOG2-1:ND_LOG2] : acc_n[DW+PK_LOG2-1:PK_LOG2];
            valid_o  <= 1'b1;
            st       <= ST_IDLE;
          end else begin
            acc      <= acc_n;
            conv_cnt <= conv_cnt + 1'b1;
            sp_cnt   <= '0;
            st       <= ST_GAP;
          end
        end
        ST_GAP: if (tick_i) begin
          if (sp_cnt == SW'(SPACE_T - 1)) begin
            req_o <= 1'b1;
            st    <= ST_REQ;
          end else begin
            sp_cnt <= sp_cnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    req_o && !done_i |=> req_o); // R9
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o); // R9
  AST_VALID_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(done_i)); // R1
  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    $rose(req_o) |-> !$past(done_i)); // R3
endmodule

// File: rtl/volt_sample_avg.sv
module volt_sample_avg
  import vsa_pkg::*;
#(
  parameter int DATA_W        = 10,
  parameter int SPACE_TICKS   = 4,
  parameter int FREE_TICKS    = 400,
  parameter int SYNC_PK_TICKS = 600,
  parameter int SYNC_ND_TICKS = 300,
  parameter int PW_MIN_CYC    = 2,
  parameter int PW_SYNC_CYC   = 20,
  parameter int PW_CLR_CYC    = 60
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic [1:0]        mode_i,
  input  logic              inh_i,
  output logic              conv_req_o,
  input  logic              conv_done_i,
  input  logic [DATA_W-1:0] conv_data_i,
  output logic [DATA_W-1:0] sample_o,
  output logic              sample_valid_o,
  output logic              hist_clr_o
);
  logic drop_mode;
  logic sync_evt;
  logic trig;

  assign drop_mode = is_drop_mode(mode_i);

  vsa_pulse_class #(
    .MIN_CYC (PW_MIN_CYC),
    .SYNC_CYC(PW_SYNC_CYC),
    .CLR_CYC (PW_CLR_CYC)
  ) u_class (
    .clk   (clk),
    .rst   (rst),
    .inh_i (inh_i),
    .sync_o(sync_evt),
    .clr_o (hist_clr_o)
  );

  vsa_sched #(
    .FREE_T (FREE_TICKS),
    .SMAX_PK(SYNC_PK_TICKS),
    .SMAX_ND(SYNC_ND_TICKS)
  ) u_sched (
    .clk   (clk),
    .rst   (rst),
    .tick_i(tick_i),
    .drop_i(drop_mode),
    .sync_i(sync_evt),
    .trig_o(trig)
  );

  vsa_burst #(
    .DW     (DATA_W),
    .SPACE_T(SPACE_TICKS)
  ) u_burst (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (tick_i),
    .drop_i  (drop_mode),
    .trig_i  (trig),
    .req_o   (conv_req_o),
    .done_i  (conv_done_i),
    .data_i  (conv_data_i),
    .sample_o(sample_o),
    .valid_o (sample_valid_o)
  );
endmodule

// File: tb/volt_sample_avg_tb_top.sv
`timescale 1ns/1ps
module volt_sample_avg_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       inh = 1'b0;
  logic       done = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [9:0] data = '0;
  logic       req, valid, clr;
  logic [9:0] sample;

  always #4 clk = ~clk;

  volt_sample_avg dut_i (
    .clk(clk), .rst(rst), .tick_i(tick), .mode_i(mode), .inh_i(inh),
    .conv_req_o(req), .conv_done_i(done), .conv_data_i(data),
    .sample_o(sample), .sample_valid_o(valid), .hist_clr_o(clr)
  );

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic int adc_val(input int b, input int k);
    return b + ((k >= 16) ? 32 : 0) + (k % 4);
  endfunction

  function automatic int exp_avg(input int b, input int n);
    int s = 0;
    for (int k = 0; k < n; k++) s += adc_val(b, k);
    return (n == 16) ? s / 16 : s / 32;
  endfunction

  typedef struct { int val; int n; } exp_t;
  exp_t q[$];

  task automatic push(input int b, input int n);
    q.push_back('{exp_avg(b, n), n});
  endtask

  // timebase: one tick every 4 clocks
  initial begin
    int t = 0;
    forever begin
      @(negedge clk);
      tick = (t % 4 == 0);
      t++;
    end
  end

  // converter model: done two negedges after the request is seen
  int adc_k = 0;
  int adc_base = 100;
  int conv_tot = 0;
  initial begin
    int lat = 0;
    forever begin
      @(negedge clk);
      if (valid) adc_k = 0;
      if (done) done = 1'b0;
      else if (req) begin
        lat++;
        if (lat == 2) begin
          lat = 0;
          done = 1'b1;
          data = 10'(adc_val(adc_base, adc_k));
          adc_k++;
          conv_tot++;
        end
      end
    end
  end

  // monitor / scoreboard
  int start_cnt = 0, start_cyc = 0, clr_cnt = 0, conv_at_start = 0, gap = 0;
  bit in_b = 0, req_q = 0, valid_q = 0;
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (clr) clr_cnt++;
        if (req && !req_q) begin
          if (!in_b) begin
            start_cnt++;
            start_cyc = cyc;
            conv_at_start = conv_tot;
            in_b = 1;
          end else begin
            check(gap >= 13 && gap <= 17, "R3 conversion spacing", gap, 15);
          end
          gap = 0;
        end
        if (in_b && !req) gap++;
        if (valid) begin
          check(!valid_q, "R9 valid lasts one cycle", 1, 0);
          if (q.size() == 0) check(0, "R9 unexpected sample", int'(sample), -1);
          else begin
            e = q.pop_front();
            check(int'(sample) == e.val, "R2 averaged value", int'(sample), e.val);
            check(conv_tot - conv_at_start == e.n, "R1 conversions per burst",
                  conv_tot - conv_at_start, e.n);
          end
          in_b = 0;
          gap = 0;
        end
      end
      req_q = req;
      valid_q = valid;
    end
  end

  int fall_cyc = 0;
  task automatic pulse(input int w);
    @(negedge clk);
    inh = 1'b1;
    repeat (w) @(negedge clk);
    inh = 1'b0;
    fall_cyc = cyc;
  endtask

  task automatic wait_start(input int s0, input int tmo, input string r, output int t);
    int w = 0;
    while (start_cnt <= s0 && w < tmo) begin
      @(negedge clk); #1;
      w++;
    end
    check(start_cnt > s0, r, start_cnt, s0 + 1);
    t = start_cyc;
  endtask

  task automatic wait_drain(input int tmo);
    int w = 0;
    while (q.size() > 0 && w < tmo) begin
      @(negedge clk); #1;
      w++;
    end
    check(q.size() == 0, "R2 expected samples arrived", q.size(), 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    int ta, tb, t, f, s, c;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(req == 1'b0, "R10 request low in reset", req, 0);
    check(valid == 1'b0, "R10 valid low in reset", valid, 0);
    check(clr == 1'b0, "R10 clear low in reset", clr, 0);
    check(sample == '0, "R10 sample zero in reset", int'(sample), 0);
    rst = 1'b0;

    // R4 free-running period, peak mode
    mode = 2'b00; adc_base = 100;
    push(100, 32); push(100, 32);
    wait_start(0, 2000, "R4 first free burst", ta);
    wait_start(1, 2000, "R4 second free burst", tb);
    check(tb - ta == 1600, "R4 free-running period", tb - ta, 1600);
    wait_drain(1000);

    // R5 sync in drop mode, then R8 fallback window for drop mode
    mode = 2'b10; adc_base = 300;
    push(300, 16);
    s = start_cnt;
    pulse(5);
    f = fall_cyc;
    wait_start(s, 50, "R5 sync starts burst", t);
    check(t - f >= 1 && t - f <= 5, "R5 sync-to-request delay", t - f, 3);
    wait_drain(800);
    push(300, 16);
    s = start_cnt;
    wait_start(s, 4000, "R8 free run resumes", t);
    check(t - f >= 2750 && t - f <= 2850, "R8 fallback in drop mode", t - f, 2800);
    wait_drain(800);

    // R5 sync in peak mode
    mode = 2'b01; adc_base = 50;
    push(50, 32);
    s = start_cnt;
    pulse(5);
    f = fall_cyc;
    wait_start(s, 50, "R5 sync starts burst", t);
    check(t - f >= 1 && t - f <= 5, "R5 sync-to-request delay", t - f, 3);
    wait_drain(1000);

    // R6 ignored widths, R7 history clear
    s = start_cnt; c = clr_cnt;
    pulse(1);
    repeat (40) @(negedge clk);
    pulse(40);
    repeat (40) @(negedge clk); #1;
    check(start_cnt == s, "R6 ignored pulses start nothing", start_cnt, s);
    check(clr_cnt == c, "R6 ignored pulses clear nothing", clr_cnt, c);
    pulse(80);
    repeat (40) @(negedge clk); #1;
    check(clr_cnt == c + 1, "R7 single history clear", clr_cnt, c + 1);
    check(start_cnt == s, "R7 long pulse starts nothing", start_cnt, s);

    // R8 fallback window for peak mode
    push(50, 32);
    wait_start(s, 4500, "R8 free run resumes", t);
    check(t - f >= 3950 && t - f <= 4050, "R8 fallback in peak mode", t - f, 4000);
    wait_drain(1000);

    // R9 sync during a running burst is dropped
    mode = 2'b00; adc_base = 700;
    push(700, 32);
    s = start_cnt;
    pulse(5);
    wait_start(s, 50, "R5 sync starts burst", t);
    repeat (100) @(negedge clk);
    pulse(5);
    wait_drain(1000);
    s = start_cnt;
    repeat (60) @(negedge clk); #1;
    check(start_cnt == s, "R9 trigger during burst dropped", start_cnt, s);

    finish_run();
  end
endmodule